// File: doc/BRIEF.md
# Dual-Path Sample Capture Buffer

This block takes a snapshot of two complex sample streams at the same instants: the transmit stream, which leaves the predistorter, and the observation stream, which returns from the power amplifier through an ADC. A controller arms the block with a single-cycle pulse. The block then stores a fixed number of sample pairs into two equal banks. When the last pair is stored it raises a done flag. It keeps the captured data for readback by the coefficient estimator until the next arm pulse.

The observation samples are narrower than the transmit samples. Before storage, each observation component is widened to the common 16-bit word by placing the ADC bits in the upper positions and filling the low bits with zeros. Both banks are written through one address counter. Entry k in one bank and entry k in the other bank were therefore taken in the same clock cycle.

Top module: `dual_capture_buffer`

## Requirements
- R1: After synchronous reset, `cap_done` is low and the read outputs `rd_re`/`rd_im` are zero.
- R2: An `arm` pulse while idle or done moves the block to the armed state. If the block was done, `cap_done` falls in the cycle after the pulse.
- R3: While armed, the first cycle with `smp_valid` high stores its pair at index 0. Each later valid cycle stores at the next index. Cycles with `smp_valid` low store nothing and do not advance the index. Samples presented before arming are discarded.
- R4: `cap_done` rises in the cycle after the DEPTH-th stored pair, and not earlier.
- R5: Index k of the transmit bank and index k of the observation bank hold samples presented in the same cycle.
- R6: Each observation component is stored as the 14 ADC bits in bits 15..2, with bits 1..0 zero.
- R7: In the done state, a read request (`rd_en` high) returns the addressed entry on `rd_re`/`rd_im` in the following cycle. `rd_path` = 0 selects the transmit bank and `rd_path` = 1 selects the observation bank.
- R8: A read request outside the done state returns zero in the following cycle. Any cycle without a read request also returns zero in the following cycle.
- R9: An `arm` pulse during capture is ignored: the capture continues and ends in done. An `arm` pulse while already armed keeps the block armed.
- R10: In the done state, further valid samples are ignored, and both the data and `cap_done` hold until the next `arm`. That `arm` starts a new capture, which overwrites the banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Single-cycle pulse that starts a new capture |
| smp_valid | input | 1 | Marks a cycle that carries a sample pair on both paths |
| tx_re | input | 16 | Transmit path, in-phase component |
| tx_im | input | 16 | Transmit path, quadrature component |
| fb_re | input | 14 | Observation path, in-phase ADC sample |
| fb_im | input | 14 | Observation path, quadrature ADC sample |
| rd_en | input | 1 | Read request |
| rd_path | input | 1 | Bank select: 0 transmit, 1 observation |
| rd_addr | input | 10 | Read index |
| rd_re | output | 16 | Read data, in-phase |
| rd_im | output | 16 | Read data, quadrature |
| cap_done | output | 1 | High while a complete capture is held |

## Verification
On every cycle, the assertions check the control sequencing. Specifically, they check these points:
- the index holds during capture cycles that carry no sample;
- `cap_done` cannot rise before the final index is written;
- the done state holds until an arm pulse, and an arm pulse during capture has no effect;
- the read outputs are zero whenever no permitted read was requested.

Only the bench scenarios can show the following:
- which sample lands at which index in each bank;
- that both banks were written at the same instants;
- that the observation data is widened correctly;
- that a second capture overwrites the first.

For these checks, the bench reads back every entry and compares it with its own model of the stream it sent.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned ADC_W    = 14;
    localparam int unsigned PAD_W    = SAMPLE_W - ADC_W;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ARMED     = 2'd1,
        ST_CAPTURING = 2'd2,
        ST_DONE      = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] re;
        logic [SAMPLE_W-1:0] im;
    } iq_t;

    // ADC word goes to the upper bits; the low bits are zero.
    function automatic logic [SAMPLE_W-1:0] widen_adc(input logic [ADC_W-1:0] x);
        return {x, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/dcap_ctrl.sv
module dcap_ctrl
    import dcap_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          in_valid,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          done
);

    cap_state_e    st, st_n;
    logic [AW-1:0] addr, addr_n;
    logic          last;

    assign last    = (addr == AW'(DEPTH - 1));
    assign wr_en   = in_valid && ((st == ST_ARMED) || (st == ST_CAPTURING));
    assign wr_addr = addr;
    assign done    = (st == ST_DONE);

    always_comb begin
        st_n   = st;
        addr_n = addr;
        unique case (st)
            ST_IDLE, ST_DONE: begin
                if (arm) begin
                    st_n   = ST_ARMED;
                    addr_n = '0;
                end
            end
            ST_ARMED: begin
                if (in_valid) begin
                    st_n   = ST_CAPTURING;
                    addr_n = AW'(1);
                end
            end
            ST_CAPTURING: begin
                if (in_valid) begin
                    if (last) begin
                        st_n   = ST_DONE;
                        addr_n = '0;
                    end else begin
                        addr_n = addr + AW'(1);
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            addr <= '0;
        end else begin
            st   <= st_n;
            addr <= addr_n;
        end
    end

    // R3: a capture cycle without a sample leaves the index untouched
    assert_hold_index_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CAPTURING && !in_valid) |=> $stable(addr));

    // R4: done never follows a write to any index but the last
    assert_no_early_done_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !last) |=> !done);

    // R9: arm during capture does not disturb the capture
    assert_ignore_rearm_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CAPTURING && arm && !(in_valid && last)) |=> (st == ST_CAPTURING));

    // R10: a finished capture stays finished until armed
    assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> done);

    // R2: arming from done leads to the armed state
    assert_rearm_from_done_R2: assert property (@(posedge clk) disable iff (rst)
        (done && arm) |=> (st == ST_ARMED && !done));

endmodule

// File: rtl/dcap_bank.sv
module dcap_bank
    import dcap_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  iq_t           wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output iq_t           rdata
);

    iq_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/dual_capture_buffer.sv
module dual_capture_buffer
    import dcap_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] tx_re,
    input  logic [SAMPLE_W-1:0] tx_im,
    input  logic [ADC_W-1:0]    fb_re,
    input  logic [ADC_W-1:0]    fb_im,
    input  logic                rd_en,
    input  logic                rd_path,
    input  logic [AW-1:0]       rd_addr,
    output logic [SAMPLE_W-1:0] rd_re,
    output logic [SAMPLE_W-1:0] rd_im,
    output logic                cap_done
);

    localparam int unsigned NPATH = 2;

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          rd_ok;
    logic          rd_ok_q;
    logic          rd_path_q;
    iq_t           wdata [NPATH];
    iq_t           rdata [NPATH];
    iq_t           sel;

    dcap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .in_valid (smp_valid),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .done     (cap_done)
    );

    assign wdata[0] = '{re: tx_re, im: tx_im};
    assign wdata[1] = '{re: widen_adc(fb_re), im: widen_adc(fb_im)};

    assign rd_ok = rd_en && cap_done;

    for (genvar p = 0; p < NPATH; p++) begin : g_bank
        dcap_bank #(.DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (wdata[p]),
            .re    (rd_ok),
            .raddr (rd_addr),
            .rdata (rdata[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ok_q   <= 1'b0;
            rd_path_q <= 1'b0;
        end else begin
            rd_ok_q   <= rd_ok;
            rd_path_q <= rd_path;
        end
    end

    always_comb begin
        sel = rd_path_q ? rdata[1] : rdata[0];
        if (!rd_ok_q) begin
            sel = '0;
        end
    end

    assign rd_re = sel.re;
    assign rd_im = sel.im;

    // R8: no permitted read request means zero on the read outputs
    assert_read_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && cap_done) |=> (rd_re == '0 && rd_im == '0));

endmodule

// File: tb/dual_capture_buffer_tb.sv
module dual_capture_buffer_tb;

    localparam int unsigned DEPTH = 1024;
    localparam int unsigned AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0;
    logic          smp_valid = 1'b0;
    logic [15:0]   tx_re = '0, tx_im = '0;
    logic [13:0]   fb_re = '0, fb_im = '0;
    logic          rd_en = 1'b0;
    logic          rd_path = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_re, rd_im;
    logic          cap_done;

    int checks = 0;
    int fails  = 0;
    bit reported = 0;

    logic [15:0] m_tx_re [DEPTH];
    logic [15:0] m_tx_im [DEPTH];
    logic [13:0] m_fb_re [DEPTH];
    logic [13:0] m_fb_im [DEPTH];

    dual_capture_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
        .tx_re(tx_re), .tx_im(tx_im), .fb_re(fb_re), .fb_im(fb_im),
        .rd_en(rd_en), .rd_path(rd_path), .rd_addr(rd_addr),
        .rd_re(rd_re), .rd_im(rd_im), .cap_done(cap_done)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] exp_widen(input logic [13:0] x);
        return {x, 2'b00};
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic read_word(input logic sel, input int addr,
                             output logic [15:0] re, output logic [15:0] im);
        rd_en   = 1'b1;
        rd_path = sel;
        rd_addr = AW'(addr);
        step();
        rd_en = 1'b0;
        re = rd_re;
        im = rd_im;
    endtask

    task automatic check_entry(input int addr);
        logic [15:0] re, im;
        read_word(1'b0, addr, re, im);
        chk(re == m_tx_re[addr] && im == m_tx_im[addr], "R7", "tx readback",
            {re, im}, {m_tx_re[addr], m_tx_im[addr]});
        read_word(1'b1, addr, re, im);
        // R5 and R6: same-index feedback entry, widened
        chk(re == exp_widen(m_fb_re[addr]) && im == exp_widen(m_fb_im[addr]),
            "R5/R6", "fb readback", {re, im},
            {exp_widen(m_fb_re[addr]), exp_widen(m_fb_im[addr])});
    endtask

    // mode 0: random data with gaps; mode 1: directed corner values, no gaps
    task automatic run_capture(input int mode, input bit arm_mid, input bit probe_read);
        int idx = 0;
        bit probed = 0;
        while (idx < DEPTH) begin
            smp_valid = (mode == 1) ? 1'b1 : ($urandom % 4 != 0);
            if (mode == 1) begin
                case (idx % 4)
                    0: begin fb_re = 14'h3FFF; fb_im = 14'h0000; end
                    1: begin fb_re = 14'h2000; fb_im = 14'h1FFF; end
                    2: begin fb_re = 14'h0001; fb_im = 14'h3FFF; end
                    default: begin fb_re = 14'h0000; fb_im = 14'h2000; end
                endcase
                tx_re = 16'(idx);
                tx_im = ~16'(idx);
            end else begin
                tx_re = 16'($urandom);
                tx_im = 16'($urandom);
                fb_re = 14'($urandom);
                fb_im = 14'($urandom);
            end
            arm = arm_mid && (idx == DEPTH / 2);
            rd_en = probe_read && !probed && (idx == 10);
            if (smp_valid) begin
                m_tx_re[idx] = tx_re;
                m_tx_im[idx] = tx_im;
                m_fb_re[idx] = fb_re;
                m_fb_im[idx] = fb_im;
            end
            step();
            if (rd_en) begin
                probed = 1;
                chk(rd_re == 16'h0 && rd_im == 16'h0, "R8", "read during capture",
                    {rd_re, rd_im}, 32'h0);
            end
            rd_en = 1'b0;
            arm = 1'b0;
            if (smp_valid) idx++;
            if (idx == DEPTH - 1 && smp_valid) begin
                chk(cap_done == 1'b0, "R4", "done before last sample", 32'(cap_done), 32'h0);
            end
        end
        smp_valid = 1'b0;
        chk(cap_done == 1'b1, "R4", "done after last sample", 32'(cap_done), 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [15:0] re, im;
        void'($urandom(32'd20240611));

        // R1: reset state
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(cap_done == 1'b0, "R1", "done after reset", 32'(cap_done), 32'h0);
        chk(rd_re == 16'h0 && rd_im == 16'h0, "R1", "read data after reset", {rd_re, rd_im}, 32'h0);

        // R8: read while idle returns zero
        read_word(1'b0, 0, re, im);
        chk(re == 16'h0 && im == 16'h0, "R8", "read while idle", {re, im}, 32'h0);

        // R3: samples before arming are dropped
        smp_valid = 1'b1;
        tx_re = 16'hDEAD; tx_im = 16'hBEEF; fb_re = 14'h1234; fb_im = 14'h0ABC;
        repeat (5) step();
        smp_valid = 1'b0;
        chk(cap_done == 1'b0, "R3", "no capture while idle", 32'(cap_done), 32'h0);

        // R2: arm, then R9: arm again while armed, then a gap before data
        arm = 1'b1; step(); arm = 1'b0;
        repeat (3) step();
        arm = 1'b1; step(); arm = 1'b0;
        repeat (4) step();
        chk(cap_done == 1'b0, "R9", "still armed, not done", 32'(cap_done), 32'h0);

        // R3, R4, R9, R8: random capture with gaps, rearm midway, probe read
        run_capture(0, 1'b1, 1'b1);

        // R10: samples after done are ignored; done holds
        smp_valid = 1'b1;
        for (int k = 0; k < 20; k++) begin
            tx_re = 16'($urandom); tx_im = 16'($urandom);
            fb_re = 14'($urandom); fb_im = 14'($urandom);
            step();
        end
        smp_valid = 1'b0;
        chk(cap_done == 1'b1, "R10", "done holds without arm", 32'(cap_done), 32'h1);

        // R8: no request in done yields zero
        step();
        chk(rd_re == 16'h0 && rd_im == 16'h0, "R8", "idle read port in done", {rd_re, rd_im}, 32'h0);

        // R7, R5, R6, R3, R10: read back every entry
        for (int a = 0; a < DEPTH; a++) begin
            check_entry(a);
        end

        // R2: rearm from done drops done
        arm = 1'b1; step(); arm = 1'b0;
        chk(cap_done == 1'b0, "R2", "done falls after rearm", 32'(cap_done), 32'h0);
        read_word(1'b1, 0, re, im);
        chk(re == 16'h0 && im == 16'h0, "R8", "read while armed", {re, im}, 32'h0);

        // R10, R6: second capture overwrites, with full-scale ADC codes
        run_capture(1, 1'b0, 1'b0);
        check_entry(0);
        check_entry(1);
        check_entry(2);
        check_entry(3);
        check_entry(DEPTH - 1);
        for (int k = 0; k < 40; k++) begin
            check_entry(int'($urandom % DEPTH));
        end

        report();
        $finish;
    end

endmodule